// File: doc/BRIEF.md
# Clock Buffer Power-Up Sequencer

This block sequences the start-up of a differential clock fan-out buffer. After the supply is reported good it waits a fixed settling interval. It then holds the outputs off until three things are all true: the reference clock is valid, the power-good pin is high, and the PLL reports lock. Only then does it raise the output enable. All four status inputs are asynchronous and pass through a synchronizer before the state machine or the strap logic sees them.

The power-good pin has two roles. Its first rising edge after power-on captures the frequency-select strap and the bandwidth-mode strap. Every later low level is a power-down request, and every later high level ends it. The bandwidth strap is a three-level pin. It arrives already digitised as a 2-bit level code, and the block turns it into a 2-bit mode readback. Software can override the mode. The effective mode then follows the software bits, while the readback keeps the captured pin value.

Top module: `clkbuf_pwrup_seq`

## Requirements
- R1: While reset is asserted and right after it, state_o is 0, out_en_o is 0, straps_valid_o is 0, pwrdn_o is 0, and freq_sel_o and bw_rdbk_o are 0.
- R2: A high supply_ok_i moves the block from state 0 to state 1 on the SYNC_STAGES+1-th rising clock edge after it is applied. A low supply_ok_i returns the block to state 0 from any state after the same latency and clears the captured straps.
- R3: State 1 lasts exactly CLK_KHZ*SETTLE_US/1000 cycles. The block then enters state 2.
- R4: The block leaves state 2 for state 3 only when the synchronized clock-valid, power-good and PLL-lock inputs are all high. With the reference clock invalid it stays in state 2.
- R5: out_en_o is high exactly while state_o is 3.
- R6: In state 3, a low clock-valid or a low power-good returns the block to state 2.
- R7: The first rising power-good level seen while the supply is good captures freq_sel_pin_i into freq_sel_o and the decoded level into bw_rdbk_o, and sets straps_valid_o.
- R8: Once the straps are captured, later changes of the strap pins and later power-good pulses leave freq_sel_o and bw_rdbk_o unchanged until the supply is lost.
- R9: pwrdn_o is high while the straps are captured and the synchronized power-good is low. It drops once power-good returns high.
- R10: Level code decode: 2'b00 (low) reads back as 2'b00 (low bandwidth), 2'b01 (mid) as 2'b01 (bypass), 2'b10 (high) as 2'b11 (high bandwidth). The unused code 2'b11 reads back as 2'b01.
- R11: With sw_override_i high, bw_eff_o equals sw_bw_mode_i. With it low, bw_eff_o equals bw_rdbk_o. The override never changes bw_rdbk_o.
- R12: With clock, lock and power-good already present, out_en_o rises SETTLE+SYNC_STAGES+2 cycles after supply_ok_i is applied. This is within 1.8 ms at CLK_KHZ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply above threshold (asynchronous) |
| refclk_valid_i | input | 1 | Input reference clock detected (asynchronous) |
| pll_locked_i | input | 1 | PLL lock indication (asynchronous) |
| pwr_good_i | input | 1 | Power-good / power-down pin (asynchronous) |
| freq_sel_pin_i | input | 1 | Frequency-select strap pin |
| bw_level_i | input | 2 | Digitised tri-level bandwidth strap code |
| sw_override_i | input | 1 | Software mode override enable |
| sw_bw_mode_i | input | 2 | Software bandwidth mode |
| state_o | output | 2 | Sequencer state 0..3 |
| out_en_o | output | 1 | Clock outputs enable |
| straps_valid_o | output | 1 | Straps captured since power-on |
| pwrdn_o | output | 1 | Power-down request active |
| freq_sel_o | output | 1 | Captured frequency select |
| bw_rdbk_o | output | 2 | Captured bandwidth mode readback |
| bw_eff_o | output | 2 | Effective bandwidth mode |

## Verification
On every cycle the assertions check the following:
- supply loss forces state 0;
- the settle interval has its exact length, measured by a counter in the checker;
- state 2 never exits to state 3 without all three conditions;
- state 3 drops back to state 2 when the clock or power-good is lost;
- captured straps hold steady;
- the readback never shows the unused code.

The bench scenarios cover the rest:
- the exact latency figures;
- that pin changes and repeated power-good pulses after capture have no effect;
- the power-down indication;
- the override path;
- the decode across random strap patterns over repeated power cycles.

// File: rtl/clkbuf_pwrup_pkg.sv
package clkbuf_pwrup_pkg;

  typedef enum logic [1:0] {
    PWR_OFF    = 2'd0,
    PWR_SETTLE = 2'd1,
    PWR_WAIT   = 2'd2,
    PWR_RUN    = 2'd3
  } pwr_state_e;

  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_MID  = 2'b01;
  localparam logic [1:0] LVL_HIGH = 2'b10;

  localparam logic [1:0] BW_LOW    = 2'b00;
  localparam logic [1:0] BW_BYPASS = 2'b01;
  localparam logic [1:0] BW_HIGH   = 2'b11;

  typedef struct packed {
    logic       freq_sel;
    logic [1:0] bw_mode;
  } strap_t;

  // Level code to mode readback; the unused code falls back to bypass.
  function automatic logic [1:0] decode_bw_level(input logic [1:0] lvl);
    logic [1:0] m;
    case (lvl)
      LVL_LOW:  m = BW_LOW;
      LVL_MID:  m = BW_BYPASS;
      LVL_HIGH: m = BW_HIGH;
      default:  m = BW_BYPASS;
    endcase
    return m;
  endfunction

  // Settle interval in system clock cycles, never below one.
  function automatic int unsigned settle_cycles(input int unsigned clk_khz,
                                                input int unsigned settle_us);
    int unsigned c;
    c = (clk_khz * settle_us) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/pwrup_sync.sv
module pwrup_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int unsigned CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/pwrup_settle_timer.sv
module pwrup_settle_timer #(
  parameter int unsigned LIMIT = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);

  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + CW'(1);
  end

  assign done_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/pwrup_strap_latch.sv
module pwrup_strap_latch
  import clkbuf_pwrup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       pg_i,
  input  logic       freq_pin_i,
  input  logic [1:0] bw_level_i,
  output logic       pg_rise_o,
  output logic       captured_o,
  output strap_t     strap_o
);

  logic   pg_q;
  logic   captured_q;
  strap_t strap_q;
  logic   capture;

  assign pg_rise_o = pg_i && !pg_q;
  assign capture   = pg_rise_o && !captured_q && !clear_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q       <= 1'b0;
      captured_q <= 1'b0;
      strap_q    <= '0;
    end else if (clear_i) begin
      pg_q       <= 1'b0;
      captured_q <= 1'b0;
      strap_q    <= '0;
    end else begin
      pg_q <= pg_i;
      if (capture) begin
        captured_q       <= 1'b1;
        strap_q.freq_sel <= freq_pin_i;
        strap_q.bw_mode  <= decode_bw_level(bw_level_i);
      end
    end
  end

  assign captured_o = captured_q;
  assign strap_o    = strap_q;

endmodule

// File: rtl/clkbuf_pwrup_seq.sv
module clkbuf_pwrup_seq
  import clkbuf_pwrup_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 100000,
  parameter int unsigned SETTLE_US   = 200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok_i,
  input  logic       refclk_valid_i,
  input  logic       pll_locked_i,
  input  logic       pwr_good_i,
  input  logic       freq_sel_pin_i,
  input  logic [1:0] bw_level_i,
  input  logic       sw_override_i,
  input  logic [1:0] sw_bw_mode_i,
  output logic [1:0] state_o,
  output logic       out_en_o,
  output logic       straps_valid_o,
  output logic       pwrdn_o,
  output logic       freq_sel_o,
  output logic [1:0] bw_rdbk_o,
  output logic [1:0] bw_eff_o
);

  localparam int unsigned SETTLE_LEN = settle_cycles(CLK_KHZ, SETTLE_US);
  localparam int unsigned NSTAT      = 4;

  // Synchronized status inputs.
  logic [NSTAT-1:0] stat_s;
  logic sup_s, clk_s, lock_s, pg_s;

  pwrup_sync #(.WIDTH(NSTAT), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({pwr_good_i, pll_locked_i, refclk_valid_i, supply_ok_i}),
    .sync_o  (stat_s)
  );

  assign sup_s  = stat_s[0];
  assign clk_s  = stat_s[1];
  assign lock_s = stat_s[2];
  assign pg_s   = stat_s[3];

  // Named internal events.
  pwr_state_e state_q, state_d;
  logic settle_done;
  logic run_ready;
  logic run_drop;
  logic pg_rise;
  logic strap_clear;

  pwrup_settle_timer #(.LIMIT(SETTLE_LEN)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (state_q == PWR_SETTLE),
    .done_o (settle_done)
  );

  assign run_ready   = clk_s && pg_s && lock_s;
  assign run_drop    = !clk_s || !pg_s;
  assign strap_clear = !sup_s;

  always_comb begin
    state_d = state_q;
    if (!sup_s) begin
      state_d = PWR_OFF;
    end else begin
      case (state_q)
        PWR_OFF:    state_d = PWR_SETTLE;
        PWR_SETTLE: if (settle_done) state_d = PWR_WAIT;
        PWR_WAIT:   if (run_ready)   state_d = PWR_RUN;
        PWR_RUN:    if (run_drop)    state_d = PWR_WAIT;
        default:    state_d = PWR_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PWR_OFF;
    else        state_q <= state_d;
  end

  // Strap capture on the first power-good rise.
  strap_t strap;
  logic   captured;

  pwrup_strap_latch u_straps (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (strap_clear),
    .pg_i       (pg_s),
    .freq_pin_i (freq_sel_pin_i),
    .bw_level_i (bw_level_i),
    .pg_rise_o  (pg_rise),
    .captured_o (captured),
    .strap_o    (strap)
  );

  assign state_o        = state_q;
  assign out_en_o       = (state_q == PWR_RUN);
  assign straps_valid_o = captured;
  assign pwrdn_o        = captured && !pg_s;
  assign freq_sel_o     = strap.freq_sel;
  assign bw_rdbk_o      = strap.bw_mode;
  assign bw_eff_o       = sw_override_i ? sw_bw_mode_i : strap.bw_mode;

endmodule

// File: rtl/pwrup_seq_checker.sv
module pwrup_seq_checker #(
  parameter int unsigned SETTLE_LEN = 20000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sup_s,
  input logic       clk_s,
  input logic       lock_s,
  input logic       pg_s,
  input logic [1:0] state,
  input logic       out_en,
  input logic       straps_valid,
  input logic       freq,
  input logic [1:0] bw_rdbk
);

  int unsigned dly_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            dly_cnt <= 0;
    else if (state == 2'd1) dly_cnt <= dly_cnt + 1;
    else                   dly_cnt <= 0;
  end

  assert_supply_loss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_s |=> state == 2'd0);

  assert_settle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && sup_s && dly_cnt < SETTLE_LEN - 1) |=> state == 2'd1);

  assert_settle_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && sup_s && dly_cnt == SETTLE_LEN - 1) |=> state == 2'd2);

  assert_run_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && !(clk_s && pg_s && lock_s)) |=> state != 2'd3);

  assert_enable_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> $past(lock_s && clk_s && pg_s));

  assert_run_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd3 && sup_s && (!clk_s || !pg_s)) |=> state == 2'd2);

  assert_straps_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (straps_valid && sup_s) |=> (straps_valid && $stable(freq) && $stable(bw_rdbk)));

  assert_rdbk_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    straps_valid |-> bw_rdbk != 2'b10);

endmodule

bind clkbuf_pwrup_seq pwrup_seq_checker #(.SETTLE_LEN(SETTLE_LEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sup_s        (sup_s),
  .clk_s        (clk_s),
  .lock_s       (lock_s),
  .pg_s         (pg_s),
  .state        (state_o),
  .out_en       (out_en_o),
  .straps_valid (straps_valid_o),
  .freq         (freq_sel_o),
  .bw_rdbk      (bw_rdbk_o)
);

// File: tb/test_clkbuf_pwrup_seq.sv
module test_clkbuf_pwrup_seq;

  localparam int CLK_PERIOD = 10;
  localparam int T_KHZ      = 1000;
  localparam int T_US       = 200;
  localparam int S          = 2;
  localparam int N          = T_KHZ * T_US / 1000;
  localparam int LIMIT_1MS8 = T_KHZ * 18 / 10;
  localparam int WD_CYCLES  = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 0, refclk_valid = 0, pll_locked = 0, pwr_good = 0;
  logic freq_pin = 0, sw_override = 0;
  logic [1:0] bw_level = 0, sw_mode = 0;
  logic [1:0] state, bw_rdbk, bw_eff;
  logic out_en, straps_valid, pwrdn, freq_sel;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkbuf_pwrup_seq #(.CLK_KHZ(T_KHZ), .SETTLE_US(T_US), .SYNC_STAGES(S)) i_clkbuf_pwrup_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .refclk_valid_i(refclk_valid),
    .pll_locked_i(pll_locked), .pwr_good_i(pwr_good), .freq_sel_pin_i(freq_pin),
    .bw_level_i(bw_level), .sw_override_i(sw_override), .sw_bw_mode_i(sw_mode),
    .state_o(state), .out_en_o(out_en), .straps_valid_o(straps_valid), .pwrdn_o(pwrdn),
    .freq_sel_o(freq_sel), .bw_rdbk_o(bw_rdbk), .bw_eff_o(bw_eff)
  );

  function automatic int exp_bw(input logic [1:0] lvl);
    if (lvl == 2'b10) return 3;
    if (lvl == 2'b00) return 0;
    return 1;
  endfunction

  function automatic int exp_eff(input logic ovr, input logic [1:0] sw, input int rd);
    return ovr ? int'(sw) : rd;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'd4242));
    tick(3);
    // R1 reset state
    check("R1 state in reset", state, 0);
    check("R1 out_en in reset", out_en, 0);
    rst_n = 1'b1;
    tick(1);
    check("R1 state after reset", state, 0);
    check("R1 straps_valid", straps_valid, 0);
    check("R1 pwrdn", pwrdn, 0);
    check("R1 rdbk", {freq_sel, bw_rdbk}, 0);

    // R2 / R3 power on, exact latency
    freq_pin = 1; bw_level = 2'b10; pll_locked = 1;
    supply_ok = 1;
    tick(S);
    check("R2 not yet left off", state, 0);
    tick(1);
    check("R2 entered settle", state, 1);
    tick(N - 1);
    check("R3 still settling", state, 1);
    tick(1);
    check("R3 entered wait", state, 2);

    // R7 / R10 first power-good rise, R4 no clock
    pwr_good = 1;
    tick(S + 1);
    check("R7 straps valid", straps_valid, 1);
    check("R7 freq captured", freq_sel, 1);
    check("R10 high level decodes 11", bw_rdbk, 3);
    tick(50);
    check("R4 no clock stays wait", state, 2);
    check("R5 out_en low in wait", out_en, 0);

    // R4 / R5 clock arrives
    refclk_valid = 1;
    tick(S + 1);
    check("R4 entered run", state, 3);
    check("R5 out_en in run", out_en, 1);

    // R8 pin changes ignored
    freq_pin = 0; bw_level = 2'b00;
    tick(5);
    check("R8 freq held", freq_sel, 1);
    check("R8 mode held", bw_rdbk, 3);

    // R6 / R9 power-down and exit
    pwr_good = 0;
    tick(S + 1);
    check("R6 pg low leaves run", state, 2);
    check("R5 out_en off in pwrdn", out_en, 0);
    check("R9 pwrdn high", pwrdn, 1);
    pwr_good = 1;
    tick(S + 1);
    check("R9 pwrdn cleared", pwrdn, 0);
    check("R6 back to run", state, 3);
    check("R8 mode held after second rise", bw_rdbk, 3);
    check("R8 freq held after second rise", freq_sel, 1);

    // R6 clock loss
    refclk_valid = 0;
    tick(S + 1);
    check("R6 clock loss leaves run", state, 2);
    refclk_valid = 1;
    tick(S + 1);
    check("R6 clock back", state, 3);

    // R11 override
    sw_override = 1; sw_mode = 2'b00;
    #1;
    check("R11 eff follows sw", bw_eff, 0);
    check("R11 rdbk untouched", bw_rdbk, 3);
    sw_override = 0;
    #1;
    check("R11 eff follows rdbk", bw_eff, 3);

    // R2 supply loss
    supply_ok = 0;
    tick(S + 1);
    check("R2 supply loss to off", state, 0);
    check("R2 straps cleared", straps_valid, 0);
    check("R5 out_en off", out_en, 0);

    // R12 latency with everything present, R7 capture with pg already high
    freq_pin = 0; bw_level = 2'b01;
    tick(2);
    supply_ok = 1;
    cnt = 0;
    while (!out_en && cnt < 5000) begin
      tick(1);
      cnt++;
    end
    check("R12 power-on latency", cnt, N + S + 2);
    check("R12 within 1.8ms", int'(cnt <= LIMIT_1MS8), 1);
    check("R7 capture with pg early", freq_sel, 0);
    check("R10 mid decodes 01", bw_rdbk, 1);

    // Random strap patterns over power cycles
    for (int i = 0; i < 10; i++) begin
      logic [1:0] lvl, swm;
      logic fp, ov;
      supply_ok = 0; pwr_good = 0;
      tick(S + 2);
      lvl = 2'($urandom()); swm = 2'($urandom());
      fp = 1'($urandom()); ov = 1'($urandom());
      if (i == 0) lvl = 2'b11;
      if (i == 1) lvl = 2'b00;
      bw_level = lvl; freq_pin = fp; sw_override = ov; sw_mode = swm;
      supply_ok = 1;
      tick(N + S + 2);
      check("R4 wait without pg", state, 2);
      pwr_good = 1;
      tick(S + 1);
      check("R4 run after pg", state, 3);
      check("R7 random freq", freq_sel, int'(fp));
      check("R10 random decode", bw_rdbk, exp_bw(lvl));
      check("R11 random eff", bw_eff, exp_eff(ov, swm, exp_bw(lvl)));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule